// File: doc/BRIEF.md
# Microcoded Instruction Sequencer

This block is the control unit of a small 8-bit accumulator processor. A T-state counter steps through the phases of each instruction, and a combinational microcode decoder turns the current T-state, the 4-bit opcode held by the instruction register and the carry and zero flags into a set of control lines. Each control line drives one datapath action. The registers, the memory and the ALU sit outside the block. The sequencer only decides which of them act in each cycle.

Every instruction opens with the same two fetch phases. After those, the opcode-specific phases run until the microcode raises `done`, and the counter then returns to T0. Short instructions therefore take 3 cycles instead of the worst-case 5. Conditional branches do not need flag-indexed microcode. Instead they raise a carry-gated or zero-gated jump line, and the block combines those lines with the flags into one PC load strobe. A halt instruction freezes the sequencer until reset.

The reset input is asserted asynchronously and released through a synchronizer, so the first T0 phase of a run starts two clock edges after `rst_n` rises.

Top module: `seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `tstate` is 0 at once, without waiting for a clock, and the control lines show the T0 word. Any halt is cleared.
- R2: In T0, exactly `pc_out` and `mar_in` are high, whatever the opcode and flags.
- R3: In T1, exactly `mem_out`, `ir_in` and `pc_inc` are high, whatever the opcode and flags.
- R4: The opcode bits are decoded as NOP=0000, LDA=0001, ADD=0010, SUB=0011, STA=0100, LDI=0101, JMP=0110, JC=0111, JZ=1000, OUT=1110, HLT=1111, and 1001 through 1101 behave as NOP. Instruction lengths are 5 cycles for ADD and SUB, 4 for LDA and STA, and 3 for all other opcodes. `tstate` counts up by one each cycle. `done` is high only in the final phase, and the following clock returns `tstate` to 0.
- R5: LDA raises `ir_out`+`mar_in` in T2 and `mem_out`+`a_in`+`done` in T3. STA raises `ir_out`+`mar_in` in T2 and `a_out`+`mem_wr`+`done` in T3.
- R6: ADD and SUB raise `ir_out`+`mar_in` in T2, `mem_out`+`b_in` in T3, and `alu_out`+`a_in`+`flag_upd`+`done` in T4. `alu_sub` is also high in T4 for SUB only.
- R7: In T2, NOP and the unused opcodes raise only `done`. LDI raises `ir_out`+`a_in`+`done`. JMP raises `ir_out`+`jump_uncond`+`done`. OUT raises `a_out`+`out_ld`+`done`.
- R8: In T2, JC raises `ir_out`+`jump_if_c`+`done` and JZ raises `ir_out`+`jump_if_z`+`done`, independent of the flags. `pc_load` is high only when the matching flag is 1.
- R9: `pc_load` is high exactly when `jump_uncond` is high, or `jump_if_c` is high with `carry`=1, or `jump_if_z` is high with `zero`=1. It is never high otherwise.
- R10: HLT raises `halt`+`done` in T2. From the next clock on, `tstate` stays at 2 and `halt` is the only high control line, regardless of opcode and flags, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Opcode field of the instruction register |
| carry | input | 1 | Carry flag from the datapath |
| zero | input | 1 | Zero flag from the datapath |
| tstate | output | 3 | Current T-state |
| pc_out | output | 1 | Drive program counter onto the bus |
| mar_in | output | 1 | Load memory address register |
| mem_out | output | 1 | Drive memory data onto the bus |
| ir_in | output | 1 | Load instruction register |
| pc_inc | output | 1 | Increment program counter |
| ir_out | output | 1 | Drive instruction operand onto the bus |
| a_in | output | 1 | Load accumulator |
| a_out | output | 1 | Drive accumulator onto the bus |
| b_in | output | 1 | Load B register |
| alu_out | output | 1 | Drive ALU result onto the bus |
| alu_sub | output | 1 | ALU subtracts instead of adds |
| flag_upd | output | 1 | Capture carry and zero flags |
| mem_wr | output | 1 | Write memory |
| jump_uncond | output | 1 | Unconditional jump line |
| jump_if_c | output | 1 | Jump line gated by carry |
| jump_if_z | output | 1 | Jump line gated by zero |
| pc_load | output | 1 | Load program counter from the bus (flag-qualified) |
| out_ld | output | 1 | Load the output register |
| halt | output | 1 | Halt indication |
| done | output | 1 | Last phase of the current instruction |

## Verification
The properties assume that the opcode seen from T2 to the end of an instruction is the one the instruction register latched in T1. Under that assumption, the phase in which `done` appears is consistent with the counter. The flags are assumed free to change at any time, because they only qualify `pc_load`. The stimulus scrambles the opcode during T0, T1 and the halted state, and holds it steady from T2 until the instruction ends. Every opcode is swept with all four flag combinations.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned OPC_W    = 4;
  localparam int unsigned T_STATES = 5;
  localparam int unsigned T_W      = $clog2(T_STATES) < 1 ? 1 : $clog2(T_STATES);

  typedef logic [T_W-1:0] tstate_t;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP = 4'h0,
    OP_LDA = 4'h1,
    OP_ADD = 4'h2,
    OP_SUB = 4'h3,
    OP_STA = 4'h4,
    OP_LDI = 4'h5,
    OP_JMP = 4'h6,
    OP_JC  = 4'h7,
    OP_JZ  = 4'h8,
    OP_OUT = 4'hE,
    OP_HLT = 4'hF
  } opcode_e;

  typedef struct packed {
    logic pc_out;
    logic mar_in;
    logic mem_out;
    logic ir_in;
    logic pc_inc;
    logic ir_out;
    logic a_in;
    logic a_out;
    logic b_in;
    logic alu_out;
    logic alu_sub;
    logic flag_upd;
    logic mem_wr;
    logic jump_uncond;
    logic jump_if_c;
    logic jump_if_z;
    logic out_ld;
    logic halt;
    logic done;
  } ctl_t;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[N-2:0], 1'b1};
  end

  assign rst_q_n = sr_q[N-1];
endmodule

// File: rtl/seq_tcount.sv
module seq_tcount
  import seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    done,
  input  logic    halt_req,
  output tstate_t tstate,
  output logic    halted
);
  localparam tstate_t T_LAST = tstate_t'(T_STATES - 1);

  tstate_t t_q, t_d;
  logic    halted_q, halted_d;
  logic    adv_en;

  always_comb begin
    adv_en   = !halted_q;
    t_d      = t_q;
    halted_d = halted_q;
    if (halt_req) begin
      halted_d = 1'b1;
    end else if (done || (t_q == T_LAST)) begin
      t_d = '0;
    end else begin
      t_d = tstate_t'(t_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q      <= '0;
      halted_q <= 1'b0;
    end else if (adv_en) begin
      t_q      <= t_d;
      halted_q <= halted_d;
    end
  end

  assign tstate = t_q;
  assign halted = halted_q;
endmodule

// File: rtl/seq_ucode.sv
module seq_ucode
  import seq_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  tstate_t          tstate,
  input  logic             halted,
  output ctl_t             ctl
);
  always_comb begin
    ctl = '0;
    if (halted) begin
      ctl.halt = 1'b1;
    end else if (tstate == tstate_t'(0)) begin
      ctl.pc_out = 1'b1;
      ctl.mar_in = 1'b1;
    end else if (tstate == tstate_t'(1)) begin
      ctl.mem_out = 1'b1;
      ctl.ir_in   = 1'b1;
      ctl.pc_inc  = 1'b1;
    end else begin
      case (opcode)
        OP_LDA, OP_STA, OP_ADD, OP_SUB: begin
          if (tstate == tstate_t'(2)) begin
            ctl.ir_out = 1'b1;
            ctl.mar_in = 1'b1;
          end else if (tstate == tstate_t'(3)) begin
            if (opcode == OP_STA) begin
              ctl.a_out  = 1'b1;
              ctl.mem_wr = 1'b1;
              ctl.done   = 1'b1;
            end else if (opcode == OP_LDA) begin
              ctl.mem_out = 1'b1;
              ctl.a_in    = 1'b1;
              ctl.done    = 1'b1;
            end else begin
              ctl.mem_out = 1'b1;
              ctl.b_in    = 1'b1;
            end
          end else if (tstate == tstate_t'(4)) begin
            if ((opcode == OP_ADD) || (opcode == OP_SUB)) begin
              ctl.alu_out  = 1'b1;
              ctl.a_in     = 1'b1;
              ctl.flag_upd = 1'b1;
              ctl.alu_sub  = (opcode == OP_SUB);
              ctl.done     = 1'b1;
            end
          end
        end
        default: begin
          if (tstate == tstate_t'(2)) begin
            ctl.done = 1'b1;
            case (opcode)
              OP_LDI: begin ctl.ir_out = 1'b1; ctl.a_in = 1'b1; end
              OP_JMP: begin ctl.ir_out = 1'b1; ctl.jump_uncond = 1'b1; end
              OP_JC:  begin ctl.ir_out = 1'b1; ctl.jump_if_c = 1'b1; end
              OP_JZ:  begin ctl.ir_out = 1'b1; ctl.jump_if_z = 1'b1; end
              OP_OUT: begin ctl.a_out = 1'b1; ctl.out_ld = 1'b1; end
              OP_HLT: ctl.halt = 1'b1;
              default: ;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/seq_jump_gate.sv
module seq_jump_gate (
  input  logic jump_uncond,
  input  logic jump_if_c,
  input  logic jump_if_z,
  input  logic carry,
  input  logic zero,
  output logic pc_load
);
  assign pc_load = jump_uncond | (jump_if_c & carry) | (jump_if_z & zero);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             carry,
  input  logic             zero,
  output logic [T_W-1:0]   tstate,
  output logic             pc_out,
  output logic             mar_in,
  output logic             mem_out,
  output logic             ir_in,
  output logic             pc_inc,
  output logic             ir_out,
  output logic             a_in,
  output logic             a_out,
  output logic             b_in,
  output logic             alu_out,
  output logic             alu_sub,
  output logic             flag_upd,
  output logic             mem_wr,
  output logic             jump_uncond,
  output logic             jump_if_c,
  output logic             jump_if_z,
  output logic             pc_load,
  output logic             out_ld,
  output logic             halt,
  output logic             done
);
  logic    rst_q_n;
  tstate_t t_cur;
  logic    halted;
  ctl_t    ctl;

  seq_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  seq_tcount i_tcount (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .done     (ctl.done),
    .halt_req (ctl.halt & ~halted),
    .tstate   (t_cur),
    .halted   (halted)
  );

  seq_ucode i_ucode (
    .opcode (opcode),
    .tstate (t_cur),
    .halted (halted),
    .ctl    (ctl)
  );

  seq_jump_gate i_jump_gate (
    .jump_uncond (ctl.jump_uncond),
    .jump_if_c   (ctl.jump_if_c),
    .jump_if_z   (ctl.jump_if_z),
    .carry       (carry),
    .zero        (zero),
    .pc_load     (pc_load)
  );

  assign tstate      = t_cur;
  assign pc_out      = ctl.pc_out;
  assign mar_in      = ctl.mar_in;
  assign mem_out     = ctl.mem_out;
  assign ir_in       = ctl.ir_in;
  assign pc_inc      = ctl.pc_inc;
  assign ir_out      = ctl.ir_out;
  assign a_in        = ctl.a_in;
  assign a_out       = ctl.a_out;
  assign b_in        = ctl.b_in;
  assign alu_out     = ctl.alu_out;
  assign alu_sub     = ctl.alu_sub;
  assign flag_upd    = ctl.flag_upd;
  assign mem_wr      = ctl.mem_wr;
  assign jump_uncond = ctl.jump_uncond;
  assign jump_if_c   = ctl.jump_if_c;
  assign jump_if_z   = ctl.jump_if_z;
  assign out_ld      = ctl.out_ld;
  assign halt        = ctl.halt;
  assign done        = ctl.done;
endmodule

// File: rtl/seq_ctrl_chk.sv
module seq_ctrl_chk
  import seq_pkg::*;
(
  input logic           clk,
  input logic           rst_i_n,
  input logic [T_W-1:0] tstate,
  input logic           pc_out,
  input logic           mar_in,
  input logic           mem_out,
  input logic           ir_in,
  input logic           pc_inc,
  input logic           jump_uncond,
  input logic           jump_if_c,
  input logic           jump_if_z,
  input logic           pc_load,
  input logic           halt,
  input logic           done
);
  localparam logic [T_W-1:0] T_MAX = T_W'(T_STATES - 1);

  assert_t0_fetch_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tstate == '0 && !halt) |-> (pc_out && mar_in && !done));

  assert_t1_fetch_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tstate == T_W'(1) && !halt) |-> (mem_out && ir_in && pc_inc && !done));

  assert_done_wrap_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && !halt) |=> (tstate == '0));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!done && !halt && tstate != T_MAX) |=> (tstate == $past(tstate) + 1'b1));

  assert_range_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    tstate <= T_MAX);

  assert_cond_jump_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (jump_if_c || jump_if_z) |-> (tstate == T_W'(2) && done));

  assert_pc_load_src_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    pc_load |-> (jump_uncond || jump_if_c || jump_if_z));

  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    halt |=> (halt && $stable(tstate)));
endmodule

bind seq_ctrl seq_ctrl_chk i_chk (
  .clk         (clk),
  .rst_i_n     (rst_q_n),
  .tstate      (tstate),
  .pc_out      (pc_out),
  .mar_in      (mar_in),
  .mem_out     (mem_out),
  .ir_in       (ir_in),
  .pc_inc      (pc_inc),
  .jump_uncond (jump_uncond),
  .jump_if_c   (jump_if_c),
  .jump_if_z   (jump_if_z),
  .pc_load     (pc_load),
  .halt        (halt),
  .done        (done)
);

// File: tb/test_seq_ctrl.sv
module test_seq_ctrl;
  logic       clk;
  logic       rst_n;
  logic [3:0] opcode;
  logic       carry, zero;
  logic [2:0] tstate;
  logic pc_out, mar_in, mem_out, ir_in, pc_inc, ir_out, a_in, a_out, b_in;
  logic alu_out, alu_sub, flag_upd, mem_wr, jump_uncond, jump_if_c, jump_if_z;
  logic pc_load, out_ld, halt, done;

  int total = 0;
  int bad   = 0;

  localparam int B_PCO = 18, B_MARI = 17, B_MEMO = 16, B_IRI = 15, B_PCI = 14;
  localparam int B_IRO = 13, B_AI = 12, B_AO = 11, B_BI = 10, B_ALUO = 9;
  localparam int B_SUB = 8, B_FLG = 7, B_MWR = 6, B_JU = 5, B_JC = 4, B_JZ = 3;
  localparam int B_OUT = 2, B_HLT = 1, B_DONE = 0;

  seq_ctrl i_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .carry(carry), .zero(zero),
    .tstate(tstate), .pc_out(pc_out), .mar_in(mar_in), .mem_out(mem_out),
    .ir_in(ir_in), .pc_inc(pc_inc), .ir_out(ir_out), .a_in(a_in), .a_out(a_out),
    .b_in(b_in), .alu_out(alu_out), .alu_sub(alu_sub), .flag_upd(flag_upd),
    .mem_wr(mem_wr), .jump_uncond(jump_uncond), .jump_if_c(jump_if_c),
    .jump_if_z(jump_if_z), .pc_load(pc_load), .out_ld(out_ld), .halt(halt),
    .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [18:0] word_now();
    return {pc_out, mar_in, mem_out, ir_in, pc_inc, ir_out, a_in, a_out, b_in,
            alu_out, alu_sub, flag_upd, mem_wr, jump_uncond, jump_if_c,
            jump_if_z, out_ld, halt, done};
  endfunction

  function automatic logic [18:0] bits(input int a, input int b = -1,
                                       input int c = -1, input int d = -1);
    logic [18:0] w = '0;
    if (a >= 0) w[a] = 1'b1;
    if (b >= 0) w[b] = 1'b1;
    if (c >= 0) w[c] = 1'b1;
    if (d >= 0) w[d] = 1'b1;
    return w;
  endfunction

  function automatic int exp_len(input int op);
    if (op == 2 || op == 3) return 5;
    if (op == 1 || op == 4) return 4;
    return 3;
  endfunction

  function automatic logic [18:0] exp_word(input int op, input int t);
    if (t == 0) return bits(B_PCO, B_MARI);
    if (t == 1) return bits(B_MEMO, B_IRI, B_PCI);
    if (op >= 1 && op <= 4 && t == 2) return bits(B_IRO, B_MARI);
    case (op)
      1: return bits(B_MEMO, B_AI, B_DONE);
      4: return bits(B_AO, B_MWR, B_DONE);
      2, 3: begin
        if (t == 3) return bits(B_MEMO, B_BI);
        return bits(B_ALUO, B_AI, B_FLG, B_DONE) | (op == 3 ? bits(B_SUB) : 19'd0);
      end
      5:  return bits(B_IRO, B_AI, B_DONE);
      6:  return bits(B_IRO, B_JU, B_DONE);
      7:  return bits(B_IRO, B_JC, B_DONE);
      8:  return bits(B_IRO, B_JZ, B_DONE);
      14: return bits(B_AO, B_OUT, B_DONE);
      15: return bits(B_HLT, B_DONE);
      default: return bits(B_DONE);
    endcase
  endfunction

  function automatic string req_of(input int op, input int t);
    if (t == 0) return "R2";
    if (t == 1) return "R3";
    if (op == 1 || op == 4) return "R5";
    if (op == 2 || op == 3) return "R6";
    if (op == 7 || op == 8) return "R8";
    if (op == 15) return "R10";
    return "R7";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "tstate in reset", 32'(tstate), 32'd0);
    check("R1", "word in reset", 32'(word_now()), 32'(bits(B_PCO, B_MARI)));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_instr(input int op, input logic c, input logic z);
    int len = exp_len(op);
    for (int t = 0; t < len; t++) begin
      opcode = (t < 2) ? ~4'(op) : 4'(op);
      carry = c;
      zero  = z;
      #1;
      check("R4", $sformatf("tstate op=%0d t=%0d", op, t), 32'(tstate), 32'(t));
      check(req_of(op, t), $sformatf("word op=%0d t=%0d c=%0b z=%0b", op, t, c, z),
            32'(word_now()), 32'(exp_word(op, t)));
      if (op == 7 || op == 8) begin
        check("R8", $sformatf("pc_load op=%0d t=%0d c=%0b z=%0b", op, t, c, z),
              32'(pc_load), 32'((t == 2) && ((op == 7) ? c : z)));
      end else begin
        check("R9", $sformatf("pc_load op=%0d t=%0d", op, t),
              32'(pc_load), 32'((t == 2) && (op == 6)));
      end
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    opcode = 4'h0;
    carry = 1'b0;
    zero = 1'b0;
    do_reset();

    for (int op = 0; op < 15; op++) begin
      for (int f = 0; f < 4; f++) begin
        run_instr(op, f[0], f[1]);
      end
    end

    // R10: halt and freeze
    run_instr(15, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      opcode = 4'(k * 5 + 1);
      carry = k[0];
      zero  = k[1];
      #1;
      check("R10", "tstate while halted", 32'(tstate), 32'd2);
      check("R10", "word while halted", 32'(word_now()), 32'(bits(B_HLT)));
      check("R10", "pc_load while halted", 32'(pc_load), 32'd0);
      @(negedge clk);
    end

    // R1: reset clears halt, then an instruction runs normally
    do_reset();
    run_instr(6, 1'b0, 1'b0);

    // R1: reset in the middle of a SUB
    opcode = 4'h3;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R4", "tstate before mid reset", 32'(tstate), 32'd3);
    do_reset();
    run_instr(2, 1'b1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule